// File: doc/BRIEF.md
# Circular-buffer address generator

This block produces data memory addresses for one memory space of a signal processor. It holds four 16-bit pointer registers, four 16-bit signed step registers and one length register shared by all pointers. On each clock it can issue one address. The address can come straight from the request (direct), from a chosen pointer with the pointer left as it was (pointer-direct), or from a chosen pointer that is then advanced by a chosen step (post-modify). When the length register is nonzero, post-modify keeps the pointer inside a circular buffer. The buffer has that many words and starts at a base aligned to the smallest power of two that is not below the length. When the length is zero, the pointer steps linearly and wraps modulo 2^16.

Software or the instruction pipeline loads every register through a single write port. The same registers can be read back through a combinational read port. Instruction decode and the memory are outside the block. A processor with two data spaces uses two instances.

Top module: `modulo_agu`

## Requirements
- R1: After a clock edge with `rst_n` low, every register reads back 0, `addr_o` is 0 and `addr_valid_o` is 0.
- R2: Register codes on `wr_addr_i`/`rd_addr_i` are: pointers 0..3, steps 4..7, length 8. A write lands at the next edge and is visible on `rd_data_o` after that edge. Codes 9..15 ignore writes and read 0.
- R3: Mode 1 (direct) places `direct_addr_i` on `addr_o` with `addr_valid_o` high after the next edge, and changes no register.
- R4: Mode 2 (pointer-direct) places the selected pointer on `addr_o` after the next edge and leaves that pointer unchanged.
- R5: Mode 3 (post-modify) with length 0 places the old pointer on `addr_o` and sets the pointer to pointer + step, modulo 2^16.
- R6: The step is a two's-complement 16-bit value, so a negative step moves the pointer down.
- R7: With length L nonzero, the step is taken on the offset within the 2^k-aligned block (2^k being the smallest power of two ≥ L). An offset that reaches L or beyond has L subtracted. The base bits above the block are kept. Valid for |step| ≤ L and an in-buffer pointer.
- R8: With length L nonzero, an offset that goes below 0 has L added.
- R9: When a post-modify and a load target the same pointer in one cycle, the loaded value wins.
- R10: Mode 0 (idle) drives `addr_valid_o` low after the next edge, holds `addr_o` and changes no register.
- R11: Back-to-back post-modify requests on one pointer each see the value left by the previous one, giving one address per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 idle, 1 direct, 2 pointer-direct, 3 post-modify |
| ptr_sel_i | input | 2 | Pointer used by modes 2 and 3 |
| mod_sel_i | input | 2 | Step register used by mode 3 |
| direct_addr_i | input | 16 | Address for mode 1 |
| wr_en_i | input | 1 | Register load strobe |
| wr_addr_i | input | 4 | Register code to load |
| wr_data_i | input | 16 | Load value |
| rd_addr_i | input | 4 | Register code to read back |
| rd_data_o | output | 16 | Readback value (combinational) |
| addr_o | output | 16 | Generated address (registered) |
| addr_valid_o | output | 1 | `addr_o` carries a new address |

## Verification
`addr_o` and `addr_valid_o` come from one register, so a request made before an edge shows up right after that edge. Register loads and pointer post-updates also land at that edge. Because readback is combinational, they are visible on `rd_data_o` during the cycle that follows. The bench drives inputs on the falling edge and advances its model on the rising edge. It compares all three outputs 2 ns after each rising edge, which puts every expected value exactly one edge behind its stimulus.

// File: rtl/agu_pkg.sv
// Shared definitions for the circular-buffer address generator.
// Assumes at most four pointers and four step registers, so that the
// register codes below stay fixed.
package agu_pkg;

    typedef enum logic [1:0] {
        AGU_IDLE    = 2'd0,
        AGU_DIRECT  = 2'd1,
        AGU_PTRDIR  = 2'd2,
        AGU_POSTMOD = 2'd3
    } agu_mode_e;

    localparam int REGCODE_W   = 4;
    localparam int PTR_CODE0   = 0;
    localparam int STEP_CODE0  = 4;
    localparam int LEN_CODE    = 8;

endpackage

// File: rtl/agu_mask_gen.sv
// Block mask generator: returns (smallest power of two >= len) - 1.
// It smears the bits of len-1 to the right with a log-depth shift-or
// tree. Assumes len > 0; the result for len == 0 is unused by the caller.
module agu_mask_gen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] mask_o
);
    localparam int STAGES = $clog2(AW);

    logic [AW-1:0] stg [STAGES+1];

    // Seed the smear with len-1.
    assign stg[0] = len_i - AW'(1);

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_smear
            // Each stage doubles the width of the filled run.
            assign stg[k+1] = stg[k] | (stg[k] >> (1 << k));
        end
    endgenerate

    assign mask_o = stg[STAGES];

endmodule

// File: rtl/agu_circ_step.sv
// Next-pointer arithmetic. Adds a signed step to a pointer, either
// linearly (len == 0) or inside a circular buffer of len words whose base
// is aligned to the enclosing power of two. Wrapping uses one correction,
// so it assumes |step| <= len and an offset below len.
module agu_circ_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] next_o
);
    logic [AW-1:0]   mask;
    logic [AW-1:0]   offset;
    logic signed [AW+1:0] sum_w;
    logic signed [AW+1:0] len_w;
    logic signed [AW+1:0] fixed_w;

    agu_mask_gen #(.AW(AW)) u_mask (
        .len_i  (len_i),
        .mask_o (mask)
    );

    // Offset of the pointer inside its aligned block.
    assign offset = ptr_i & mask;
    assign len_w  = $signed({2'b00, len_i});
    assign sum_w  = $signed({2'b00, offset}) + $signed({{2{step_i[AW-1]}}, step_i});

    // Fold the stepped offset back into [0, len).
    always_comb begin
        if (sum_w < 0) begin
            fixed_w = sum_w + len_w;
        end else if (sum_w >= len_w) begin
            fixed_w = sum_w - len_w;
        end else begin
            fixed_w = sum_w;
        end
    end

    // Pick linear or circular result.
    always_comb begin
        if (len_i == '0) begin
            next_o = ptr_i + step_i;
        end else begin
            next_o = (ptr_i & ~mask) | (fixed_w[AW-1:0] & mask);
        end
    end

endmodule

// File: rtl/agu_regfile.sv
// Pointer, step and length registers with one load port, one post-update
// port and a combinational readback port. A load to a pointer takes
// priority over a post-update of the same pointer in the same cycle.
// Assumes NPTR <= 4 and NSTEP <= 4 (fixed register codes).
module agu_regfile
    import agu_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NPTR  = 4,
    parameter int NSTEP = 4,
    localparam int PSW  = $clog2(NPTR)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [REGCODE_W-1:0]      wr_addr_i,
    input  logic [AW-1:0]             wr_data_i,
    input  logic                      upd_en_i,
    input  logic [PSW-1:0]            upd_sel_i,
    input  logic [AW-1:0]             upd_val_i,
    input  logic [REGCODE_W-1:0]      rd_addr_i,
    output logic [AW-1:0]             rd_data_o,
    output logic [NPTR-1:0][AW-1:0]   ptr_o,
    output logic [NSTEP-1:0][AW-1:0]  step_o,
    output logic [AW-1:0]             len_o
);
    logic [NPTR-1:0][AW-1:0]  ptr_q;
    logic [NSTEP-1:0][AW-1:0] step_q;
    logic [AW-1:0]            len_q;

    genvar i;
    generate
        for (i = 0; i < NPTR; i++) begin : g_ptr
            logic load_hit;
            logic upd_hit;
            assign load_hit = wr_en_i && (wr_addr_i == REGCODE_W'(PTR_CODE0 + i));
            assign upd_hit  = upd_en_i && (upd_sel_i == PSW'(i));
            // Pointer register: load first, post-update second.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q[i] <= '0;
                end else if (load_hit) begin
                    ptr_q[i] <= wr_data_i;
                end else if (upd_hit) begin
                    ptr_q[i] <= upd_val_i;
                end
            end
        end

        for (i = 0; i < NSTEP; i++) begin : g_step
            // Step register: written only through the load port.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    step_q[i] <= '0;
                end else if (wr_en_i && (wr_addr_i == REGCODE_W'(STEP_CODE0 + i))) begin
                    step_q[i] <= wr_data_i;
                end
            end
        end
    endgenerate

    // Length register shared by all pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_en_i && (wr_addr_i == REGCODE_W'(LEN_CODE))) begin
            len_q <= wr_data_i;
        end
    end

    // Readback mux; unused codes return zero.
    always_comb begin
        rd_data_o = '0;
        for (int n = 0; n < NPTR; n++) begin
            if (rd_addr_i == REGCODE_W'(PTR_CODE0 + n)) rd_data_o = ptr_q[n];
        end
        for (int n = 0; n < NSTEP; n++) begin
            if (rd_addr_i == REGCODE_W'(STEP_CODE0 + n)) rd_data_o = step_q[n];
        end
        if (rd_addr_i == REGCODE_W'(LEN_CODE)) rd_data_o = len_q;
    end

    assign ptr_o  = ptr_q;
    assign step_o = step_q;
    assign len_o  = len_q;

endmodule

// File: rtl/agu_addr_reg.sv
// Output stage: registers the address chosen by the request mode and
// flags it valid. Idle cycles clear the flag and hold the last address.
module agu_addr_reg
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  agu_mode_e     mode_i,
    input  logic [AW-1:0] direct_addr_i,
    input  logic [AW-1:0] ptr_val_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o
);
    // Capture the address for the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            unique case (mode_i)
                AGU_IDLE: begin
                    valid_o <= 1'b0;
                end
                AGU_DIRECT: begin
                    addr_o  <= direct_addr_i;
                    valid_o <= 1'b1;
                end
                default: begin
                    addr_o  <= ptr_val_i;
                    valid_o <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/modulo_agu.sv
// Top of the address generator for one data memory space. It issues one
// address per cycle in direct, pointer-direct or post-modify mode. Post-
// modify advances the selected pointer by a signed step, wrapping inside
// a circular buffer when the shared length register is nonzero.
// Assumes NPTR and NSTEP are powers of two no larger than four.
module modulo_agu
    import agu_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NPTR  = 4,
    parameter int NSTEP = 4,
    localparam int PSW  = $clog2(NPTR),
    localparam int SSW  = $clog2(NSTEP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [PSW-1:0]       ptr_sel_i,
    input  logic [SSW-1:0]       mod_sel_i,
    input  logic [AW-1:0]        direct_addr_i,
    input  logic                 wr_en_i,
    input  logic [REGCODE_W-1:0] wr_addr_i,
    input  logic [AW-1:0]        wr_data_i,
    input  logic [REGCODE_W-1:0] rd_addr_i,
    output logic [AW-1:0]        rd_data_o,
    output logic [AW-1:0]        addr_o,
    output logic                 addr_valid_o
);
    agu_mode_e                mode;
    logic [NPTR-1:0][AW-1:0]  ptr_q;
    logic [NSTEP-1:0][AW-1:0] step_q;
    logic [AW-1:0]            len_q;
    logic [AW-1:0]            sel_ptr;
    logic [AW-1:0]            sel_step;
    logic [AW-1:0]            next_ptr;
    logic                     upd_en;

    assign mode     = agu_mode_e'(mode_i);
    assign sel_ptr  = ptr_q[ptr_sel_i];
    assign sel_step = step_q[mod_sel_i];
    assign upd_en   = (mode == AGU_POSTMOD);

    agu_regfile #(.AW(AW), .NPTR(NPTR), .NSTEP(NSTEP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .upd_en_i  (upd_en),
        .upd_sel_i (ptr_sel_i),
        .upd_val_i (next_ptr),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .ptr_o     (ptr_q),
        .step_o    (step_q),
        .len_o     (len_q)
    );

    agu_circ_step #(.AW(AW)) u_step (
        .ptr_i  (sel_ptr),
        .step_i (sel_step),
        .len_i  (len_q),
        .next_o (next_ptr)
    );

    agu_addr_reg #(.AW(AW)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .direct_addr_i (direct_addr_i),
        .ptr_val_i     (sel_ptr),
        .addr_o        (addr_o),
        .valid_o       (addr_valid_o)
    );

endmodule

// File: rtl/agu_checker.sv
// Temporal checks for modulo_agu, attached by bind. Watches the ports and
// the register file outputs. Assumes the register codes of agu_pkg.
module agu_checker
    import agu_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NPTR  = 4,
    parameter int NSTEP = 4,
    localparam int PSW  = $clog2(NPTR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [PSW-1:0]       ptr_sel_i,
    input  logic [AW-1:0]        direct_addr_i,
    input  logic                 wr_en_i,
    input  logic [REGCODE_W-1:0] wr_addr_i,
    input  logic [AW-1:0]        wr_data_i,
    input  logic [AW-1:0]        addr_o,
    input  logic                 addr_valid_o,
    input  logic [NPTR-1:0][AW-1:0] ptr_q,
    input  logic [AW-1:0]        sel_ptr,
    input  logic [AW-1:0]        sel_step,
    input  logic [AW-1:0]        len_q
);
    function automatic logic [AW-1:0] ptr_at(input logic [PSW-1:0] idx);
        return ptr_q[idx];
    endfunction

    // R3: direct request appears one edge later.
    a_r3_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1) |=> (addr_valid_o && addr_o == $past(direct_addr_i)));

    // R10: idle request clears the valid flag.
    a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> !addr_valid_o);

    // R4: pointer-direct emits the pointer and leaves it as it was.
    a_r4_ptrdir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && !wr_en_i) |=>
            (addr_o == $past(sel_ptr) && ptr_at($past(ptr_sel_i)) == $past(sel_ptr)));

    // R5: linear post-modify emits the old pointer and adds the step.
    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && len_q == '0 && !wr_en_i) |=>
            (addr_o == $past(sel_ptr) &&
             ptr_at($past(ptr_sel_i)) == AW'($past(sel_ptr) + $past(sel_step))));

    // R9: a load beats a post-update of the same pointer.
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && wr_en_i && wr_addr_i == REGCODE_W'(ptr_sel_i)) |=>
            (ptr_at($past(ptr_sel_i)) == $past(wr_data_i)));

endmodule

bind modulo_agu agu_checker #(.AW(AW), .NPTR(NPTR), .NSTEP(NSTEP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .ptr_sel_i     (ptr_sel_i),
    .direct_addr_i (direct_addr_i),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .addr_o        (addr_o),
    .addr_valid_o  (addr_valid_o),
    .ptr_q         (ptr_q),
    .sel_ptr       (sel_ptr),
    .sel_step      (sel_step),
    .len_q         (len_q)
);

// File: tb/sim_modulo_agu.sv
// Self-checking bench: a behavioural model tracks the registers and the
// expected outputs, and every clock is compared.
module sim_modulo_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [1:0]  ptr_sel_i = 2'd0;
    logic [1:0]  mod_sel_i = 2'd0;
    logic [15:0] direct_addr_i = 16'd0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = 4'd0;
    logic [15:0] wr_data_i = 16'd0;
    logic [3:0]  rd_addr_i = 4'd0;
    logic [15:0] rd_data_o;
    logic [15:0] addr_o;
    logic        addr_valid_o;

    int errors = 0;
    int checks = 0;
    string cur = "R1";

    int m_ptr [4];
    int m_step [4];
    int m_len;
    int e_addr;
    int e_vld;

    always #4 clk = ~clk;

    modulo_agu u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ptr_sel_i(ptr_sel_i),
        .mod_sel_i(mod_sel_i), .direct_addr_i(direct_addr_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .addr_o(addr_o), .addr_valid_o(addr_valid_o)
    );

    function automatic int sx16(int v);
        return (v & 16'h8000) != 0 ? (v & 16'hFFFF) - 65536 : (v & 16'hFFFF);
    endfunction

    function automatic int next_ptr(int p, int st, int len);
        int blk; int off; int s;
        if (len == 0) return (p + sx16(st)) & 16'hFFFF;
        blk = 1;
        while (blk < len) blk = blk * 2;
        off = p % blk;
        s = off + sx16(st);
        if (s < 0) s = s + len;
        else if (s >= len) s = s - len;
        return (p - off) + s;
    endfunction

    function automatic int model_rd(int a);
        if (a < 4) return m_ptr[a];
        if (a < 8) return m_step[a-4];
        if (a == 8) return m_len;
        return 0;
    endfunction

    // Model advances on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_step[i] = 0; end
            m_len = 0; e_addr = 0; e_vld = 0;
        end else begin
            case (mode_i)
                2'd0: e_vld = 0;
                2'd1: begin e_addr = int'(direct_addr_i); e_vld = 1; end
                2'd2: begin e_addr = m_ptr[ptr_sel_i]; e_vld = 1; end
                default: begin
                    e_addr = m_ptr[ptr_sel_i]; e_vld = 1;
                    m_ptr[ptr_sel_i] = next_ptr(m_ptr[ptr_sel_i], m_step[mod_sel_i], m_len);
                end
            endcase
            if (wr_en_i) begin
                if (wr_addr_i < 4) m_ptr[wr_addr_i] = int'(wr_data_i);
                else if (wr_addr_i < 8) m_step[wr_addr_i-4] = int'(wr_data_i);
                else if (wr_addr_i == 8) m_len = int'(wr_data_i);
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur, what, act, exp);
        end
    endtask

    // One cycle: drive on falling edge, compare 2 ns after rising edge.
    task automatic cyc(int m, int ps, int ms, int da, int we, int wa, int wd, int ra);
        @(negedge clk);
        mode_i = 2'(m); ptr_sel_i = 2'(ps); mod_sel_i = 2'(ms);
        direct_addr_i = 16'(da); wr_en_i = (we != 0);
        wr_addr_i = 4'(wa); wr_data_i = 16'(wd); rd_addr_i = 4'(ra);
        @(posedge clk);
        #2;
        chk("valid", int'(addr_valid_o), e_vld);
        chk("addr", int'(addr_o), e_addr);
        chk("rd_data", int'(rd_data_o), model_rd(ra));
    endtask

    task automatic ld(int wa, int wd);
        cyc(0, 0, 0, 0, 1, wa, wd, wa);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state of every register and the output.
        cur = "R1";
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        cyc(3, 1, 1, 16'h55AA, 1, 1, 16'h1111, 1);
        rst_n = 1'b1;
        for (int a = 0; a < 9; a++) cyc(0, 0, 0, 0, 0, 0, 0, a);

        // R2: loads and readback; unused codes ignore writes and read 0.
        cur = "R2";
        ld(0, 16'h0100); ld(4, 16'h0001); ld(1, 16'hFFFF); ld(5, 16'h0002);
        ld(12, 16'hBEEF);
        cyc(0, 0, 0, 0, 0, 0, 0, 12);
        for (int a = 0; a < 9; a++) cyc(0, 0, 0, 0, 0, 0, 0, a);

        // R3: direct address, no register change.
        cur = "R3";
        cyc(1, 0, 0, 16'hA5C3, 0, 0, 0, 0);
        cyc(1, 0, 0, 16'h0007, 0, 0, 0, 0);

        // R4: pointer-direct leaves the pointer alone.
        cur = "R4";
        cyc(2, 0, 0, 0, 0, 0, 0, 0);
        cyc(2, 1, 0, 0, 0, 0, 0, 1);

        // R5: linear post-modify, including the 16-bit wrap FFFF + 2.
        cur = "R5";
        cyc(3, 0, 0, 0, 0, 0, 0, 0);
        cyc(3, 1, 1, 0, 0, 0, 0, 1);

        // R11: back-to-back post-modify on one pointer.
        cur = "R11";
        cyc(3, 0, 0, 0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0, 0, 0, 0);

        // R6: negative step moves down (-3 = FFFD).
        cur = "R6";
        ld(6, 16'hFFFD);
        cyc(3, 0, 2, 0, 0, 0, 0, 0);
        cyc(3, 0, 2, 0, 0, 0, 0, 0);

        // R7: length 5, block of 8 at base 0x40; 0x43 + 3 wraps to 0x41.
        cur = "R7";
        ld(8, 5); ld(2, 16'h0043); ld(7, 3);
        cyc(3, 2, 3, 0, 0, 0, 0, 2);
        cyc(3, 2, 3, 0, 0, 0, 0, 2);
        cyc(3, 2, 3, 0, 0, 0, 0, 2);

        // R8: 0x41 - 3 wraps up to 0x43 inside the length-5 buffer.
        cur = "R8";
        ld(3, 16'h1241);
        cyc(3, 3, 2, 0, 0, 0, 0, 3);
        cyc(3, 3, 2, 0, 0, 0, 0, 3);

        // R9: load and post-update on pointer 0 in one cycle.
        cur = "R9";
        cyc(3, 0, 0, 0, 1, 0, 16'h1234, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);

        // R10: idle clears valid and holds the address.
        cur = "R10";
        cyc(1, 0, 0, 16'h0F0F, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 8);

        // R7/R8 mixed traffic: length 8, steps within +-8.
        cur = "R7";
        ld(8, 8);
        for (int n = 0; n < 400; n++) begin
            int m; int we; int wa; int wd;
            m  = int'($urandom_range(0, 3));
            we = int'($urandom_range(0, 3) == 0);
            wa = int'($urandom_range(0, 14));
            if (wa >= 8) wa = wa + 1;
            if (wa >= 4 && wa < 8) wd = int'($urandom_range(0, 16)) - 8;
            else wd = int'($urandom_range(0, 65535));
            cyc(m, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 65535)), we, wa, wd & 16'hFFFF,
                int'($urandom_range(0, 15)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule